// File: doc/BRIEF.md
# Prescaled Up/Down Interrupt Timer

This block is a programmable timer that raises a level interrupt request. Timing events come from one of two sources: every CPU cycle, marked by a clock enable, or each rising edge of video address bit 12. Each event advances a prescaler that runs either as a full 8-bit counter or as a 3-bit counter in its low bits. Each prescaler terminal value clocks an 8-bit main counter. The main counter moves down or up, according to two independent direction bits. When it passes its terminal value it reloads and, if enabled, latches an interrupt.

Software reaches the block through an eight-entry write port selected by a 3-bit index. The prescaler and counter load values are scrambled: each written byte is XORed with a mask byte held in a separate register. The interrupt remains asserted until a write disables the timer.

Top module: `prescaled_irq_timer`

## Requirements
- R1: Synchronous active-high reset clears the prescaler, counter, XOR mask, configuration (source 0, no direction, 8-bit prescaler), enable, the stored previous video bit and the interrupt.
- R2: Index 0 sets the enable from data bit 0; index 3 sets it; index 2 clears it. A write that leaves the enable cleared (index 2, or index 0 with bit 0 low) also drops `irq` after that clock edge.
- R3: Index 1 stores the configuration: bit 7 count down, bit 6 count up, bit 2 selects the 3-bit prescaler, bits [1:0] select the source. The new configuration governs the edges after the write.
- R4: Index 6 stores the mask. Index 4 loads the prescaler, and index 5 loads the counter, with data XOR mask, using the mask held before that edge. A load takes priority over an advance of the same register on the same edge.
- R5: With source 0, the prescaler advances on each edge where `cpu_ce` is high. With source 1, it advances on each edge where `vaddr12` is 1 and was 0 at the previous edge; a steady high level does not advance it. Sources 2 and 3 never advance it.
- R6: In 8-bit prescaler mode, the prescaler increments modulo 256. The counter is clocked when the new prescaler value is 255.
- R7: In 3-bit mode, only prescaler bits [2:0] increment and wrap, while bits [7:3] hold. The counter is clocked when the new low bits are 7.
- R8: Counting down (bit 7 set, bit 6 clear), a clock decrements the counter. A result of 0 becomes 255 and latches `irq` on that edge if enabled.
- R9: Counting up (bit 6 set, bit 7 clear), a clock increments the counter. A result of 255 becomes 0 and latches `irq` on that edge if enabled.
- R10: With both direction bits set, or neither set, a counter clock leaves the counter unchanged.
- R11: `irq` is sticky until acknowledged as in R2. It rises only on an edge where the enable was already set. A wrap that occurs while the timer is disabled is not remembered when the timer is enabled later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | CPU cycle enable, one pulse per CPU cycle |
| vaddr12 | input | 1 | Video address bit 12, sampled each clock |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register index 0..7 (index 7 has no effect) |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench goes after the edge where a terminal count falls exactly one prescaler step away. A design that compares the old counter value instead of the new one would raise `irq` one period late, or raise it on the 0→255 underflow. Disabled wraps followed by a later enable are exercised, which catches a design that stores the event in a hidden flag. A held-high video bit and the reserved sources are driven for hundreds of cycles, which exposes level-triggered or ungated advancing. Frozen directions, masked loads, and loads colliding with advances run through random traffic, which shows a stale mask or the wrong priority as a wrong interrupt cycle.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

    localparam int DW      = 8;
    localparam int SHORT_W = 3;

    typedef enum logic [1:0] {
        SRC_CPU  = 2'd0,
        SRC_VID  = 2'd1,
        SRC_RSV2 = 2'd2,
        SRC_RSV3 = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        REG_ENA = 3'd0,
        REG_CFG = 3'd1,
        REG_OFF = 3'd2,
        REG_ON  = 3'd3,
        REG_PRE = 3'd4,
        REG_CNT = 3'd5,
        REG_KEY = 3'd6,
        REG_AUX = 3'd7
    } reg_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_UP   = 2'd2
    } dir_e;

    typedef struct packed {
        logic down;
        logic up;
        logic short_pre;
        src_e src;
    } cfg_t;

    function automatic cfg_t decode_cfg(input logic [7:0] d);
        cfg_t c;
        c.down      = d[7];
        c.up        = d[6];
        c.short_pre = d[2];
        c.src       = src_e'(d[1:0]);
        return c;
    endfunction

    function automatic dir_e dir_of(input cfg_t c);
        if (c.down && !c.up)      return DIR_DOWN;
        else if (c.up && !c.down) return DIR_UP;
        else                      return DIR_HOLD;
    endfunction

endpackage

// File: rtl/irq_tick_src.sv
module irq_tick_src
    import irq_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_ce,
    input  logic vaddr12,
    input  src_e src,
    output logic tick
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= vaddr12;
    end

    always_comb begin
        unique case (src)
            SRC_CPU: tick = cpu_ce;
            SRC_VID: tick = vaddr12 && !prev_q;
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_prescaler.sv
module irq_prescaler #(
    parameter int W       = 8,
    parameter int SHORT_W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         short_mode,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] pre_o,
    output logic         carry
);
    localparam logic [W-1:0]       FULL_TOP  = {W{1'b1}};
    localparam logic [SHORT_W-1:0] SHORT_TOP = {SHORT_W{1'b1}};

    logic [W-1:0] pre_q;
    logic [W-1:0] step_val;
    logic         at_top;

    generate
        if (SHORT_W < W) begin : g_split
            logic [SHORT_W-1:0] low_nxt;
            assign low_nxt = pre_q[SHORT_W-1:0] + 1'b1;
            always_comb begin
                if (short_mode) begin
                    step_val = {pre_q[W-1:SHORT_W], low_nxt};
                    at_top   = (low_nxt == SHORT_TOP);
                end else begin
                    step_val = pre_q + 1'b1;
                    at_top   = (step_val == FULL_TOP);
                end
            end
        end else begin : g_flat
            always_comb begin
                step_val = pre_q + 1'b1;
                at_top   = (step_val == FULL_TOP) || (short_mode && 1'b0);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       pre_q <= '0;
        else if (load) pre_q <= load_val;
        else if (adv)  pre_q <= step_val;
    end

    assign carry = adv && !load && at_top;
    assign pre_o = pre_q;
endmodule

// File: rtl/irq_counter.sv
module irq_counter
    import irq_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  dir_e         dir,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_o,
    output logic         wrap
);
    localparam logic [W-1:0] TOP      = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] UP_LAST  = TOP - ONE;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;
    logic         hit;

    always_comb begin
        cnt_nxt = cnt_q;
        hit     = 1'b0;
        unique case (dir)
            DIR_DOWN: begin
                hit     = (cnt_q == ONE);
                cnt_nxt = hit ? TOP : cnt_q - ONE;
            end
            DIR_UP: begin
                hit     = (cnt_q == UP_LAST);
                cnt_nxt = hit ? '0 : cnt_q + ONE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (step) cnt_q <= cnt_nxt;
    end

    assign wrap  = step && !load && hit;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/prescaled_irq_timer.sv
module prescaled_irq_timer
    import irq_timer_pkg::*;
#(
    parameter int DATA_W  = irq_timer_pkg::DW,
    parameter int SHORT_W = irq_timer_pkg::SHORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_ce,
    input  logic              vaddr12,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq
);
    cfg_t              cfg_q;
    logic [DATA_W-1:0] mask_q;
    logic              en_q;
    logic              irq_q;

    logic              tick;
    logic              pre_carry;
    logic              cnt_wrap;
    logic [DATA_W-1:0] pre_val;
    logic [DATA_W-1:0] cnt_val;
    logic              ld_pre;
    logic              ld_cnt;
    logic              ack;
    logic [DATA_W-1:0] unmasked;

    assign ld_pre   = wr_en && (wr_sel == REG_PRE);
    assign ld_cnt   = wr_en && (wr_sel == REG_CNT);
    assign ack      = wr_en && ((wr_sel == REG_OFF) ||
                                ((wr_sel == REG_ENA) && !wr_data[0]));
    assign unmasked = wr_data ^ mask_q;

    irq_tick_src u_tick (
        .clk     (clk),
        .rst     (rst),
        .cpu_ce  (cpu_ce),
        .vaddr12 (vaddr12),
        .src     (cfg_q.src),
        .tick    (tick)
    );

    irq_prescaler #(.W(DATA_W), .SHORT_W(SHORT_W)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .adv        (tick),
        .short_mode (cfg_q.short_pre),
        .load       (ld_pre),
        .load_val   (unmasked),
        .pre_o      (pre_val),
        .carry      (pre_carry)
    );

    irq_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (pre_carry),
        .dir      (dir_of(cfg_q)),
        .load     (ld_cnt),
        .load_val (unmasked),
        .cnt_o    (cnt_val),
        .wrap     (cnt_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            unique case (reg_e'(wr_sel))
                REG_ENA: en_q   <= wr_data[0];
                REG_CFG: cfg_q  <= decode_cfg(wr_data[7:0]);
                REG_OFF: en_q   <= 1'b0;
                REG_ON:  en_q   <= 1'b1;
                REG_KEY: mask_q <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   irq_q <= 1'b0;
        else if (ack)              irq_q <= 1'b0;
        else if (cnt_wrap && en_q) irq_q <= 1'b1;
    end

    assign irq = irq_q;
endmodule

// File: rtl/irq_timer_checker.sv
module irq_timer_checker
    import irq_timer_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic       irq,
    input logic       en_q,
    input cfg_t       cfg_q,
    input logic [7:0] cnt_val,
    input logic [7:0] pre_val
);
    logic ack_wr;
    logic pre_wr;
    logic cnt_wr;
    assign ack_wr = wr_en && ((wr_sel == 3'd2) || ((wr_sel == 3'd0) && !wr_data[0]));
    assign pre_wr = wr_en && (wr_sel == 3'd4);
    assign cnt_wr = wr_en && (wr_sel == 3'd5);

    assert_rst_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !irq);

    assert_ack_drops_R2: assert property (@(posedge clk) disable iff (rst)
        ack_wr |=> !irq);

    assert_idle_source_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.src[1] && !pre_wr) |=> $stable(pre_val));

    assert_upper_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.short_pre && !pre_wr) |=> $stable(pre_val[7:3]));

    assert_frozen_dir_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.down == cfg_q.up && !cnt_wr) |=> $stable(cnt_val));

    assert_rise_enabled_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(en_q));

    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack_wr) |=> irq);
endmodule

bind prescaled_irq_timer irq_timer_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .irq     (irq),
    .en_q    (en_q),
    .cfg_q   (cfg_q),
    .cnt_val (cnt_val),
    .pre_val (pre_val)
);

// File: tb/prescaled_irq_timer_tb_top.sv
module prescaled_irq_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_ce = 1'b0;
    logic       vaddr12 = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    prescaled_irq_timer dut_i (
        .clk     (clk),
        .rst     (rst),
        .cpu_ce  (cpu_ce),
        .vaddr12 (vaddr12),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .irq     (irq)
    );

    // Expected-value model built from the requirements
    logic [7:0] m_pre, m_cnt, m_mask;
    logic       m_down, m_up, m_short, m_en, m_irq, m_prev;
    logic [1:0] m_src;

    function automatic logic [8:0] pre_step(input logic [7:0] p, input logic sh);
        logic [7:0] n;
        if (sh) begin
            n = {p[7:3], p[2:0] + 3'd1};
            return {(n[2:0] == 3'd7), n};
        end
        n = p + 8'd1;
        return {(n == 8'hFF), n};
    endfunction

    function automatic logic [8:0] cnt_step(input logic [7:0] c, input logic dn, input logic up);
        logic [7:0] n;
        if (dn && !up) begin
            n = c - 8'd1;
            return (n == 8'd0) ? {1'b1, 8'hFF} : {1'b0, n};
        end
        if (up && !dn) begin
            n = c + 8'd1;
            return (n == 8'hFF) ? {1'b1, 8'h00} : {1'b0, n};
        end
        return {1'b0, c};
    endfunction

    always @(posedge clk) begin
        logic tk, fire, wrp;
        logic [8:0] r;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_mask = 0; m_down = 0; m_up = 0;
            m_short = 0; m_src = 0; m_en = 0; m_irq = 0; m_prev = 0;
        end else begin
            tk   = (m_src == 2'd0 && cpu_ce) || (m_src == 2'd1 && vaddr12 && !m_prev);
            fire = 1'b0;
            wrp  = 1'b0;
            if (wr_en && wr_sel == 3'd4) m_pre = wr_data ^ m_mask;
            else if (tk) begin
                r = pre_step(m_pre, m_short);
                m_pre = r[7:0];
                fire = r[8];
            end
            if (wr_en && wr_sel == 3'd5) m_cnt = wr_data ^ m_mask;
            else if (fire) begin
                r = cnt_step(m_cnt, m_down, m_up);
                m_cnt = r[7:0];
                wrp = r[8];
            end
            if (wr_en && (wr_sel == 3'd2 || (wr_sel == 3'd0 && !wr_data[0]))) m_irq = 1'b0;
            else if (wrp && m_en) m_irq = 1'b1;
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_en = wr_data[0];
                    3'd1: begin
                        m_down = wr_data[7]; m_up = wr_data[6];
                        m_short = wr_data[2]; m_src = wr_data[1:0];
                    end
                    3'd2: m_en = 1'b0;
                    3'd3: m_en = 1'b1;
                    3'd6: m_mask = wr_data;
                    default: ;
                endcase
            end
            m_prev = vaddr12;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Continuous comparison against the model (R6 R7 R8 R9 R4)
    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (cmp_on && !rst) check("model R4 R6 R7 R8 R9", irq, m_irq);
    end

    // Called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        check("R1 during reset", irq, 1'b0);
        rst = 1'b0;
        idle(2);
        check("R1 after reset", irq, 1'b0);
        cmp_on = 1'b1;

        // R8 + R7 + R4: masked loads, 3-bit prescaler, count down from 3
        wr(3'd6, 8'h5A);
        wr(3'd4, 8'h06 ^ 8'h5A);
        wr(3'd5, 8'h03 ^ 8'h5A);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h84);
        cpu_ce = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            check("R8 R7 down wrap timing", irq, (k >= 17));
        end
        cpu_ce = 1'b0;
        idle(3);
        check("R11 sticky", irq, 1'b1);
        wr(3'd2, 8'h00);
        check("R2 ack by index 2", irq, 1'b0);

        // R9 + R5 video edge + R11 disabled wrap not remembered
        wr(3'd6, 8'h00);
        wr(3'd1, 8'h41);
        wr(3'd4, 8'hFE);
        wr(3'd5, 8'hFE);
        vaddr12 = 1'b1;
        @(negedge clk);
        check("R11 wrap while disabled", irq, 1'b0);
        vaddr12 = 1'b0;
        wr(3'd3, 8'h00);
        idle(2);
        check("R11 no stored event", irq, 1'b0);
        wr(3'd4, 8'hFE);
        wr(3'd5, 8'hFE);
        vaddr12 = 1'b1;
        @(negedge clk);
        check("R9 up wrap raises irq", irq, 1'b1);
        wr(3'd0, 8'h00);
        check("R2 ack by index 0 bit0 low", irq, 1'b0);
        wr(3'd0, 8'h01);
        wr(3'd4, 8'hFE);
        wr(3'd5, 8'hFE);
        idle(4);
        check("R5 steady high video bit", irq, 1'b0);
        vaddr12 = 1'b0;
        @(negedge clk);
        vaddr12 = 1'b1;
        @(negedge clk);
        check("R5 second rising edge", irq, 1'b1);
        vaddr12 = 1'b0;
        wr(3'd2, 8'h00);

        // R10 frozen direction
        wr(3'd3, 8'h00);
        wr(3'd1, 8'hC0);
        wr(3'd4, 8'hFE);
        wr(3'd5, 8'h01);
        cpu_ce = 1'b1;
        idle(300);
        check("R10 both bits freeze", irq, 1'b0);
        cpu_ce = 1'b0;
        wr(3'd1, 8'h00);
        wr(3'd4, 8'hFE);
        cpu_ce = 1'b1;
        idle(300);
        check("R10 neither bit freezes", irq, 1'b0);
        cpu_ce = 1'b0;
        wr(3'd1, 8'h80);
        wr(3'd4, 8'hFE);
        cpu_ce = 1'b1;
        @(negedge clk);
        check("R10 count kept then R8", irq, 1'b1);
        cpu_ce = 1'b0;
        wr(3'd2, 8'h00);

        // R5 reserved source, R3 config takes effect after write
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h82);
        wr(3'd4, 8'hFE);
        wr(3'd5, 8'h01);
        cpu_ce = 1'b1;
        for (int i = 0; i < 300; i++) begin
            vaddr12 = i[0];
            @(negedge clk);
        end
        vaddr12 = 1'b0;
        check("R5 source 2 idle", irq, 1'b0);
        wr(3'd1, 8'h80);
        check("R3 old config on write edge", irq, 1'b0);
        @(negedge clk);
        check("R3 R6 new source counts", irq, 1'b1);
        cpu_ce = 1'b0;
        wr(3'd2, 8'h00);

        // Random traffic with model comparison
        for (int i = 0; i < 30000; i++) begin
            cpu_ce  = ($urandom % 4) != 0;
            vaddr12 = ($urandom % 3) == 0;
            if (($urandom % 12) == 0) begin
                wr_en   = 1'b1;
                wr_sel  = 3'($urandom % 8);
                wr_data = 8'($urandom);
                if (wr_sel == 3'd1 && ($urandom % 4) != 0) wr_data[1] = 1'b0;
                if (wr_sel == 3'd5 && ($urandom % 2) == 0) wr_data = 8'h02 ^ m_mask;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        cpu_ce = 1'b0;

        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset after traffic", irq, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule